// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of a set of peripheral interrupt sources is served next. Every source has a request line and an enable bit. Sources built as edge type keep a pending flag that remembers a rising request. Sources built as level type have no flag and only request while their line is high. A global enable gates all delivery. When delivery is possible, the lowest-numbered source that is both requesting and enabled wins. The block then emits a one-cycle take strobe, that source's vector address and a one-hot acknowledge.

The core reports return-from-interrupt, set-global-enable and clear-global-enable events and an instruction-retired strobe. The block uses them to keep the global enable bit. It also enforces that one instruction retires after a return or a set-global-enable before any further interrupt is taken. Software clears a pending flag by writing a one to its bit. Saving and restoring registers is left to the handler code.

Top module: `prio_vec_intc`

## Requirements
- R1: While reset is held, and after it is released, take_o is 0, ack_o is all zero, vec_o is 0 and the global enable is off, so no request is delivered until the core sets the global enable.
- R2: When several sources qualify in the same cycle, the one with the lowest index wins. Source i is delivered with vec_o = 2*(i+1), because address 0 belongs to reset and vectors are two words apart. ack_o has only bit i set while take_o is 1, and is all zero otherwise.
- R3: A source is delivered only when its bit of src_en_i and the global enable are both 1.
- R4: Taking an interrupt clears the global enable and the taken source's pending flag at the same edge. take_o is a one-cycle pulse, and the same event is never delivered twice.
- R5: A rising edge on an edge-type source sets its pending flag even while that source or the global enable is masked. The flag stays set until it is delivered or cleared by software.
- R6: A cycle with w1c_i bit i at 1 clears the pending flag of edge-type source i. If a new rising edge arrives in that same cycle, the flag stays set.
- R7: A level-type source (its LEVEL_MASK bit is 1) has no flag. It requests only while its line is high, and a request that falls before delivery is allowed is lost.
- R8: ret_i sets the global enable. No interrupt is taken until retire_i has pulsed at least once in a cycle after the return.
- R9: set_ie_i sets the global enable. Its hold behaves the same way: one retire_i after it is required before a pending source is taken.
- R10: clr_ie_i clears the global enable at once. No interrupt is taken at the edge where clr_ie_i is sampled, even when the request qualifies in that same cycle.
- R11: Setting the global enable inside a handler (nesting) lets any enabled pending source be taken again, after the retire that R9 requires.
- R12: take_o rises at the clock edge after the cycle in which a request qualifies. An edge-type request therefore appears two edges after its line rises, and a level-type request one edge after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_req_i | input | N_SRC | Request line of each source |
| src_en_i | input | N_SRC | Per-source enable bits |
| w1c_i | input | N_SRC | Write-one-to-clear strobe for pending flags |
| ret_i | input | 1 | Core executes return-from-interrupt |
| set_ie_i | input | 1 | Core sets the global enable |
| clr_ie_i | input | 1 | Core clears the global enable |
| retire_i | input | 1 | One instruction retired this cycle |
| take_o | output | 1 | One-cycle strobe: interrupt taken |
| vec_o | output | ADDR_W | Vector address of the taken source |
| ack_o | output | N_SRC | One-hot acknowledge of the taken source |

## Verification
An edge-type request is due on take_o two edges after its line rises: one edge sets the flag and one registers the take. A level-type request is due one edge after it qualifies. After a return or a set-global-enable, the take is due two edges after the retire pulse, and no edge before it may carry a take. The bench drives inputs on falling edges and queues each expected vector before the stimulus that causes it. A monitor on every falling edge pops and compares each take, and treats a take with an empty queue as a failure. Windows where nothing is due are sampled cycle by cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Vector spacing in words; address 0 is reserved for reset.
  localparam int unsigned VEC_STRIDE = 2;

  function automatic int unsigned vec_addr(input int unsigned idx);
    return (idx + 1) * VEC_STRIDE;
  endfunction
endpackage

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int unsigned N_SRC      = 8,
  parameter logic [N_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] w1c_i,
  input  logic [N_SRC-1:0] clr_take_i,
  output logic [N_SRC-1:0] raw_o
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (LEVEL_MASK[g]) begin : g_lvl
      logic unused_lvl;
      assign unused_lvl = ^{w1c_i[g], clr_take_i[g]};
      assign raw_o[g]   = req_i[g];
    end else begin : g_edge
      logic prev_q, flag_q, flag_d;
      always_comb begin
        flag_d = flag_q;
        if (w1c_i[g] || clr_take_i[g]) flag_d = 1'b0;
        if (req_i[g] && !prev_q)       flag_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          flag_q <= 1'b0;
        end else begin
          prev_q <= req_i[g];
          flag_q <= flag_d;
        end
      end
      assign raw_o[g] = flag_q;
    end
  end
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_SRC-1:0] onehot_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
    onehot_o = any_o ? (N_SRC'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/intc_gate_seq.sv
module intc_gate_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ret_i,
  input  logic set_ie_i,
  input  logic clr_ie_i,
  input  logic retire_i,
  input  logic take_now_i,
  output logic gie_o,
  output logic allow_o
);
  logic gie_q, gie_d, hold_q, hold_d;

  always_comb begin
    if (clr_ie_i)                  gie_d = 1'b0;
    else if (take_now_i)           gie_d = 1'b0;
    else if (ret_i || set_ie_i)    gie_d = 1'b1;
    else                           gie_d = gie_q;

    // The retire of the return/enable instruction itself does not count.
    if (ret_i || set_ie_i)         hold_d = 1'b1;
    else if (retire_i)             hold_d = 1'b0;
    else                           hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      gie_q  <= gie_d;
      hold_q <= hold_d;
    end
  end

  assign gie_o   = gie_q;
  assign allow_o = gie_q && !hold_q && !clr_ie_i;
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter logic [N_SRC-1:0] LEVEL_MASK = 8'b1000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_req_i,
  input  logic [N_SRC-1:0]  src_en_i,
  input  logic [N_SRC-1:0]  w1c_i,
  input  logic              ret_i,
  input  logic              set_ie_i,
  input  logic              clr_ie_i,
  input  logic              retire_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic [N_SRC-1:0]  ack_o
);
  import intc_pkg::*;
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N_SRC-1:0] raw_w, elig_w, onehot_w, clr_take_w;
  logic [IDX_W-1:0] idx_w;
  logic             any_w, allow_w, gie_w, take_now_w;

  intc_flag_bank #(.N_SRC(N_SRC), .LEVEL_MASK(LEVEL_MASK)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .req_i(src_req_i), .w1c_i(w1c_i),
    .clr_take_i(clr_take_w), .raw_o(raw_w)
  );

  assign elig_w = raw_w & src_en_i;

  intc_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .req_i(elig_w), .any_o(any_w), .idx_o(idx_w), .onehot_o(onehot_w)
  );

  assign take_now_w = allow_w && any_w;
  assign clr_take_w = take_now_w ? onehot_w : '0;

  intc_gate_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .ret_i(ret_i), .set_ie_i(set_ie_i),
    .clr_ie_i(clr_ie_i), .retire_i(retire_i), .take_now_i(take_now_w),
    .gie_o(gie_w), .allow_o(allow_w)
  );

  logic              take_q;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic [N_SRC-1:0]  ack_q, ack_d;

  always_comb begin
    vec_d = ADDR_W'(vec_addr(int'(idx_w)));
    ack_d = take_now_w ? onehot_w : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      take_q <= 1'b0;
      ack_q  <= '0;
      vec_q  <= '0;
    end else begin
      take_q <= take_now_w;
      ack_q  <= ack_d;
      if (take_now_w) vec_q <= vec_d;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign ack_o  = ack_q;
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_i,
  input logic              clr_ie_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic [N_SRC-1:0]  ack_o,
  input logic              gie_i
);
  p_ack_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $countones(ack_o) == 1);
  p_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> ack_o == '0);
  p_vec_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> vec_o != '0);
  p_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(gie_i));
  p_gie_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !gie_i);
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> ##1 !take_o);
  p_clr_now_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ie_i |=> !take_o);
endmodule

bind prio_vec_intc intc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ret_i(ret_i), .clr_ie_i(clr_ie_i),
  .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o), .gie_i(gie_w)
);

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
  localparam int N = 8;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_req, src_en, w1c;
  logic ret, set_ie, clr_ie, retire;
  logic take;
  logic [AW-1:0] vec;
  logic [N-1:0] ack;

  always #4 clk = ~clk;  // 125 MHz

  prio_vec_intc #(.N_SRC(N), .ADDR_W(AW), .LEVEL_MASK(8'b1000_0000)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_en_i(src_en),
    .w1c_i(w1c), .ret_i(ret), .set_ie_i(set_ie), .clr_ie_i(clr_ie),
    .retire_i(retire), .take_o(take), .vec_o(vec), .ack_o(ack)
  );

  typedef struct { logic [AW-1:0] v; logic [N-1:0] a; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic expect_take(input int src, input string tag);
    exp_t e;
    e.v = AW'(2 * (src + 1));
    e.a = N'(1) << src;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare every take against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && take) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected take: vec=%0h ack=%0h, expected no take", vec, ack);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (vec !== e.v || ack !== e.a) begin
          n_fail++;
          $display("FAIL %s: vec=%0h ack=%0h, expected vec=%0h ack=%0h",
                   e.tag, vec, ack, e.v, e.a);
        end
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic quiet(input int n, input string tag);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (take !== 1'b0) bad = 1;
    end
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s: take=1, expected take=0 for %0d cycles", tag, n);
    end
  endtask

  task automatic pulse_src(input logic [N-1:0] m);
    @(negedge clk); src_req = src_req | m;
    @(negedge clk); src_req = src_req & ~m;
  endtask

  task automatic pulse_ret();    @(negedge clk); ret = 1;    @(negedge clk); ret = 0;    endtask
  task automatic pulse_set();    @(negedge clk); set_ie = 1; @(negedge clk); set_ie = 0; endtask
  task automatic pulse_retire(); @(negedge clk); retire = 1; @(negedge clk); retire = 0; endtask

  task automatic scoreboard_empty(input string tag);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s: %0d takes missing, expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin @(posedge clk); cnt++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; src_req = '0; src_en = 8'hFF; w1c = '0;
    ret = 0; set_ie = 0; clr_ie = 0; retire = 0;
    cyc(3);
    n_chk++;
    if (take !== 0 || vec !== 0 || ack !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: take=%b vec=%0h ack=%0h, expected 0 0 0", take, vec, ack);
    end
    rst_n = 1;
    cyc(4);
    n_chk++;
    if (take !== 0 || vec !== 0 || ack !== 0) begin
      n_fail++;
      $display("FAIL R1 after reset: take=%b vec=%0h ack=%0h, expected 0 0 0", take, vec, ack);
    end

    // R5 / R1: edges latched while the global enable is off
    pulse_src(8'b0000_1010);
    quiet(4, "R1 R5 no delivery with global enable off");
    // R9 + R2: set enable, one retire, then lowest index wins
    expect_take(1, "R2 R9 source 1 before source 3");
    pulse_set();
    quiet(3, "R9 hold after set-enable");
    pulse_retire();
    cyc(3);
    scoreboard_empty("R12 take two edges after retire");
    // R8 + R4: return, one retire, then source 3
    expect_take(3, "R4 R8 source 3 after return");
    pulse_ret();
    quiet(2, "R8 hold after return");
    pulse_retire();
    cyc(3);
    scoreboard_empty("R8 pending served after retire");
    pulse_ret(); pulse_retire();
    quiet(3, "R4 flags cleared after delivery");

    // R3 + R5: per-source mask
    src_en[5] = 0;
    pulse_src(8'b0010_0000);
    quiet(4, "R3 masked source not delivered");
    expect_take(5, "R5 R12 source 5 once enabled");
    @(negedge clk); src_en[5] = 1;
    cyc(3);
    scoreboard_empty("R5 remembered flag");
    pulse_ret(); pulse_retire();

    // R6: write-one-to-clear
    src_en[2] = 0;
    pulse_src(8'b0000_0100);
    @(negedge clk); w1c = 8'b0000_0100;
    @(negedge clk); w1c = '0;
    src_en[2] = 1;
    quiet(4, "R6 cleared flag not delivered");

    // R10: clear-enable in same cycle as a qualifying level request
    @(negedge clk); clr_ie = 1; src_req[7] = 1;
    @(negedge clk); clr_ie = 0;
    quiet(3, "R10 clear-enable wins same cycle");
    // R7: level request lost when removed before enabled
    @(negedge clk); src_req[7] = 0;
    pulse_set(); pulse_retire();
    quiet(4, "R7 vanished level request lost");
    expect_take(7, "R7 R12 level source one edge after request");
    @(negedge clk); src_req[7] = 1;
    cyc(2);
    scoreboard_empty("R7 level delivery");
    quiet(2, "R4 level not repeated with enable off");
    @(negedge clk); src_req[7] = 0;

    // R11: nesting inside handler
    pulse_src(8'b0000_0001);
    quiet(2, "R11 pending inside handler");
    expect_take(0, "R11 nested take of source 0");
    pulse_set(); pulse_retire();
    cyc(3);
    scoreboard_empty("R11 nested delivery");

    // R2: simultaneous edges across mixed indices
    pulse_src(8'b0101_0000);
    expect_take(4, "R2 source 4 over 6");
    pulse_ret(); pulse_retire(); cyc(3);
    expect_take(6, "R2 source 6 afterwards");
    pulse_ret(); pulse_retire(); cyc(3);
    scoreboard_empty("R2 ordered delivery");

    cyc(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule